// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block walks the column address of one open SDRAM row through a read or write burst. It works one clock at a time. Burst length and counting order come from mode fields. The block takes a decoded column command with a start column and an auto-precharge flag, a burst-stop command, and a precharge command. On every cycle it drives the current column, a flag that marks a cycle as a burst beat, and a read-data-valid strobe. That strobe follows each read beat after the CAS latency.

A burst can be cut short at any clock, either by a new column command or by a precharge. Full-page bursts count around the row with no end, until a stop or a cut. The block rejects a column command or precharge that arrives while an auto-precharge burst is still running. It flags the request on an error output and leaves the burst unchanged. A mode bit can force every write to a single beat while reads keep the programmed length.

Top module: `sdram_burst_seq`

## Requirements
- R1: Length code `bl_code_i` selects the burst length: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives a full page. Every other code gives length 1.
- R2: With `ilv_i`=0, beat k of a burst of length N starting at column s drives column (s - s mod N) + ((s mod N + k) mod N).
- R3: With `ilv_i`=1, beat k drives column (s - s mod N) + ((s mod N) XOR k). For lengths 1 and 2 this matches the R2 order.
- R4: A full-page burst drives (s + k) mod 256, whatever `ilv_i` is. It does not end by itself.
- R5: When `wr_single_i`=1, a write burst has exactly one beat. Reads keep the length set by R1.
- R6: `cmd_i` encodes 0=idle, 1=read, 2=write, 3=burst stop and 4=precharge. An accepted read or write sampled at one clock edge drives its start column with `active_o`=1 from that edge on. This holds on every clock, and it replaces any running burst.
- R7: A burst stop, or an accepted precharge, sampled at an edge clears `active_o` from that edge on.
- R8: `rd_valid_o` repeats each read beat 2 or 3 cycles later (`cas_lat_i`=3 gives 3, any other value gives 2). A read beat in the cycle that carries a stop or an accepted precharge does not count. As a result, a stop leaves 1 or 2 further valid cycles.
- R9: While an auto-precharge burst is active, a read, write or precharge is ignored and raises `err_o` for the cycle after it.
- R10: During and right after reset, `active_o`, `rd_valid_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bl_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 selects interleaved counting |
| wr_single_i | input | 1 | 1 forces single-beat writes |
| cas_lat_i | input | 2 | CAS latency, 2 or 3 |
| cmd_i | input | 3 | Decoded command |
| cmd_col_i | input | 8 | Start column of a read or write |
| cmd_ap_i | input | 1 | Auto-precharge flag of a read or write |
| col_o | output | 8 | Current column |
| active_o | output | 1 | Cycle is a burst beat |
| rd_valid_o | output | 1 | Read data valid, delayed by CAS latency |
| err_o | output | 1 | Rejected command during auto-precharge burst |

## Verification
The bench builds the block with its defaults: an 8-bit column, which gives a 256-column page, and a read-valid pipe three stages deep. With the 8-bit column, the bench can start a full-page burst at column 0xFD and watch it roll through 0xFF to 0x00. A start column of 0x2D has its low bits off-aligned, so the bench can check that the upper bits of every short-length order stay fixed. The three-stage pipe allows both latencies, so the bench can count the drain after a stop at each one.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam logic [2:0] CMD_NOP  = 3'd0;
  localparam logic [2:0] CMD_RD   = 3'd1;
  localparam logic [2:0] CMD_WR   = 3'd2;
  localparam logic [2:0] CMD_STOP = 3'd3;
  localparam logic [2:0] CMD_PRE  = 3'd4;

  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;
endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       code_i,
  input  logic             wr_one_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    case (code_i)
      BL_2:    mask_o = COL_W'(1);
      BL_4:    mask_o = COL_W'(3);
      BL_8:    mask_o = COL_W'(7);
      BL_PAGE: begin
        mask_o = '1;
        full_o = 1'b1;
      end
      default: mask_o = '0;
    endcase
    if (wr_one_i) begin
      mask_o = '0;
      full_o = 1'b0;
    end
  end
endmodule

// File: rtl/col_addr_gen.sv
module col_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;

  // full page has an all-ones mask, so the sequential sum covers the wrap
  always_comb begin
    low   = ilv_i ? (start_i ^ beat_i) : (start_i + beat_i);
    col_o = (start_i & ~mask_i) | (low & mask_i);
  end
endmodule

// File: rtl/rd_valid_pipe.sv
module rd_valid_pipe #(
  parameter int MAX_CL = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] cl_i,
  input  logic       beat_i,
  output logic       valid_o
);
  logic [MAX_CL-1:0] sr_q;
  logic [1:0]        lat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[MAX_CL-2:0], beat_i};
  end

  always_comb begin
    lat     = (cl_i == 2'd3) ? 2'd3 : 2'd2;
    valid_o = sr_q[lat - 2'd1];
  end

  assert_valid_cl2_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_i != 2'd3 && valid_o) |-> $past(beat_i, 2));
  assert_valid_cl3_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cl_i == 2'd3 && valid_o) |-> $past(beat_i, 3));
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_burst_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       bl_code_i,
  input  logic             ilv_i,
  input  logic             wr_single_i,
  input  logic [1:0]       cas_lat_i,
  input  logic [2:0]       cmd_i,
  input  logic [COL_W-1:0] cmd_col_i,
  input  logic             cmd_ap_i,
  output logic [COL_W-1:0] col_o,
  output logic             active_o,
  output logic             rd_valid_o,
  output logic             err_o
);
  logic             act_q, rd_q, ap_q, ilv_q, full_q, err_q;
  logic [COL_W-1:0] start_q, beat_q, mask_q;
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             is_col, is_pre, is_stop, locked, take_col, end_now, rd_beat;

  always_comb begin
    is_col   = (cmd_i == CMD_RD) || (cmd_i == CMD_WR);
    is_pre   = (cmd_i == CMD_PRE);
    is_stop  = (cmd_i == CMD_STOP);
    locked   = act_q && ap_q;
    take_col = is_col && !locked;
    end_now  = is_stop || (is_pre && !locked);
    rd_beat  = act_q && rd_q && !end_now;
  end

  burst_len_dec #(.COL_W(COL_W)) u_dec (
    .code_i  (bl_code_i),
    .wr_one_i(wr_single_i && (cmd_i == CMD_WR)),
    .mask_o  (dec_mask),
    .full_o  (dec_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      ap_q    <= 1'b0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
    end else begin
      err_q <= (is_col || is_pre) && locked;
      if (take_col) begin
        act_q   <= 1'b1;
        rd_q    <= (cmd_i == CMD_RD);
        ap_q    <= cmd_ap_i;
        ilv_q   <= ilv_i && !dec_full;
        full_q  <= dec_full;
        mask_q  <= dec_mask;
        start_q <= cmd_col_i;
        beat_q  <= '0;
      end else if (end_now) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        if (!full_q && beat_q == mask_q) act_q  <= 1'b0;
        else                             beat_q <= beat_q + 1'b1;
      end
    end
  end

  col_addr_gen #(.COL_W(COL_W)) u_addr (
    .start_i(start_q),
    .beat_i (beat_q),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );

  rd_valid_pipe #(.MAX_CL(MAX_CL)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cl_i   (cas_lat_i),
    .beat_i (rd_beat),
    .valid_o(rd_valid_o)
  );

  assign active_o = act_q;
  assign err_o    = err_q;

  assert_start_col_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_col |=> (active_o && col_o == $past(cmd_col_i)));
  assert_cut_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_now |=> !active_o);
  assert_page_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && full_q && cmd_i == CMD_NOP) |=>
      (active_o && col_o == COL_W'($past(col_o) + 1'b1)));
  assert_locked_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && is_col) |=> (start_q == $past(start_q) && ap_q));
endmodule

// File: tb/sdram_burst_seq_test.sv
module sdram_burst_seq_test;
  localparam logic [2:0] NOP = 3'd0, RD = 3'd1, WR = 3'd2, STP = 3'd3, PRE = 3'd4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] bl_code_i = 3'd0;
  logic       ilv_i = 1'b0;
  logic       wr_single_i = 1'b0;
  logic [1:0] cas_lat_i = 2'd2;
  logic [2:0] cmd_i = 3'd0;
  logic [7:0] cmd_col_i = 8'd0;
  logic       cmd_ap_i = 1'b0;
  logic [7:0] col_o;
  logic       active_o, rd_valid_o, err_o;

  sdram_burst_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .bl_code_i(bl_code_i), .ilv_i(ilv_i),
    .wr_single_i(wr_single_i), .cas_lat_i(cas_lat_i), .cmd_i(cmd_i),
    .cmd_col_i(cmd_col_i), .cmd_ap_i(cmd_ap_i), .col_o(col_o),
    .active_o(active_o), .rd_valid_o(rd_valid_o), .err_o(err_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    bit    act;
    int    col;
    bit    rdv;
    bit    err;
    string req;
  } exp_t;

  exp_t  q[$];
  int    checks = 0, errors = 0;
  string cur_req = "R10";
  bit    done = 1'b0;

  // reference model state
  bit       m_act, m_rd, m_ap, m_full, m_ilv;
  int       m_len, m_start, m_k;
  bit [2:0] m_sr;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int len_of(logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(int s, int k, int len, bit ilv, bit full);
    int base, off;
    if (full) return (s + k) % 256;
    base = s - (s % len);
    off  = s % len;
    return ilv ? base + (off ^ k) : base + ((off + k) % len);
  endfunction

  task automatic step(logic [2:0] c, int col = 0, bit ap = 1'b0);
    bit   is_col, locked, rej, cut;
    exp_t it;
    @(negedge clk);
    cmd_i = c; cmd_col_i = 8'(col); cmd_ap_i = ap;
    is_col = (c == RD) || (c == WR);
    locked = m_act && m_ap;
    rej    = (is_col || c == PRE) && locked;
    cut    = (c == STP) || (c == PRE && !locked);
    m_sr   = {m_sr[1:0], m_act && m_rd && !cut};
    if (is_col && !locked) begin
      m_act = 1; m_k = 0; m_start = col; m_rd = (c == RD); m_ap = ap;
      m_len = len_of(bl_code_i); m_full = (bl_code_i == 3'b111);
      if (c == WR && wr_single_i) begin m_len = 1; m_full = 0; end
      m_ilv = ilv_i;
    end else if (cut) begin
      m_act = 0;
    end else if (m_act) begin
      if (!m_full && m_k == m_len - 1) m_act = 0;
      else m_k = (m_k + 1) % 256;
    end
    it.act = m_act;
    it.col = exp_col(m_start, m_k, m_len, m_ilv, m_full);
    it.rdv = (cas_lat_i == 2'd3) ? m_sr[2] : m_sr[1];
    it.err = rej;
    it.req = cur_req;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(NOP);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        chk(it.req, "active", int'(active_o), int'(it.act));
        if (it.act) chk(it.req, "col", int'(col_o), it.col);
        chk(it.req, "rd_valid", int'(rd_valid_o), int'(it.rdv));
        chk(it.req, "err", int'(err_o), int'(it.err));
      end
    end
  end

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    m_act = 0; m_rd = 0; m_ap = 0; m_full = 0; m_ilv = 0;
    m_len = 1; m_start = 0; m_k = 0; m_sr = '0;
    repeat (3) @(negedge clk);
    chk("R10", "active in reset", int'(active_o), 0);
    chk("R10", "rd_valid in reset", int'(rd_valid_o), 0);
    chk("R10", "err in reset", int'(err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10", "active after reset", int'(active_o), 0);
    chk("R10", "rd_valid after reset", int'(rd_valid_o), 0);

    // R2 / R3 / R1: every short length in both orders
    for (int t = 0; t < 2; t++) begin
      for (int c = 0; c < 4; c++) begin
        cur_req = (t == 0) ? "R2" : "R3";
        ilv_i = t[0]; bl_code_i = 3'(c);
        step(RD, 8'h2D);
        idle(len_of(3'(c)) + 3);
      end
    end
    cur_req = "R1"; bl_code_i = 3'b101; ilv_i = 1'b0;
    step(RD, 8'h6A); idle(4);

    // R4 full page wrap, then stop drain for R8 at both latencies
    for (int l = 2; l < 4; l++) begin
      cas_lat_i = 2'(l);
      idle(4);
      cur_req = "R4"; bl_code_i = 3'b111; ilv_i = 1'(l == 3);
      step(RD, 8'hFD); idle(6);
      cur_req = "R8"; step(STP); idle(5);
    end
    cas_lat_i = 2'd2; ilv_i = 1'b0; idle(4);

    // R6 cut-off by new commands, back to back
    cur_req = "R6"; bl_code_i = 3'b011;
    step(RD, 8'h40); idle(2);
    step(RD, 8'h85); step(WR, 8'h13); idle(3);
    step(RD, 8'h01); step(RD, 8'h22); step(RD, 8'h33); step(RD, 8'h47);
    idle(10);

    // R7 precharge and stop end bursts
    cur_req = "R7";
    step(RD, 8'h20); idle(2); step(PRE); idle(4);
    step(WR, 8'h90); idle(2); step(STP); idle(4);

    // R5 single-beat writes
    cur_req = "R5"; wr_single_i = 1'b1;
    step(WR, 8'h55); idle(4);
    step(RD, 8'h55); idle(10);
    wr_single_i = 1'b0;

    // R9 auto-precharge lock
    cur_req = "R9"; bl_code_i = 3'b010;
    step(RD, 8'h10, 1'b1); step(NOP);
    step(RD, 8'h99); step(PRE); idle(4);
    step(RD, 8'h30); idle(7);

    idle(2);
    @(posedge clk); #2;
    summary();
    $finish;
  end
endmodule